// File: doc/BRIEF.md
# Compare-Clear Event Timer

This block is an 8-bit up-counter with a selectable clock divider. The counter either runs freely, wrapping from 0xFF to 0x00, or is cleared each time it reaches a programmable top value held in a compare register. Every match against the compare register can toggle a waveform output. Driving that output onto a pin is controlled by a direction input. Two sticky flags record compare matches and counter wrap-arounds. Each flag can raise a shared interrupt request.

Software programs the block through a single write strobe with a 3-bit address. The compare register is loaded directly, with no shadow copy. Lowering the top value below the running count therefore makes the counter miss that match: it runs on to 0xFF, wraps, and only matches on the next pass. In toggle mode the output frequency is f_clk / (2·N·(1 + compare)), where N is the divider ratio.

Top module: `ctc_timer`

## Requirements
- R1: After reset the count is 0x00, both flags are 0, irq is 0, pin_o is 0, and the divider is stopped.
- R2: The divider select field is control bits [2:0]. Code 0 stops the counter, so the count holds. Codes 1 to 7 divide by 1, 8, 32, 64, 128, 256 and 1024. The counter advances by one on each divider tick.
- R3: With the mode field (control bits [4:3]) at any value other than 2, the counter counts 0x00 to 0xFF and wraps to 0x00. The overflow flag is set at the tick that performs the wrap.
- R4: With the mode field equal to 2, a tick at which the count equals the compare value loads 0x00 instead of incrementing. The count period is therefore compare+1 ticks.
- R5: The compare flag is set at every tick where the count equals the compare value. This holds in both modes.
- R6: A compare write (address 1) takes effect on the next tick. If the new value is below the count, no match occurs until the counter has passed 0xFF, wrapped, and reached the new value.
- R7: With the output-mode field (control bits [6:5]) equal to 1, the waveform level toggles on every match. With any other value it holds. In mode 2 the toggle period is N·(compare+1) clock cycles.
- R8: pin_oe follows pin_dir. When pin_dir is 0, pin_o is 0. When pin_dir is 1, pin_o shows the waveform level.
- R9: Writing to address 4 clears the compare flag where data bit 0 is 1 and the overflow flag where data bit 1 is 1. A set and a clear in the same cycle leave the flag set.
- R10: irq is high when (compare flag AND enable bit 0) OR (overflow flag AND enable bit 1). The enable register is at address 3.
- R11: A count write (address 0) loads the value directly, and the following tick produces no compare match even if the loaded value equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | 0 count, 1 compare, 2 control, 3 irq enable, 4 flag clear |
| reg_wdata | input | 8 | Write data |
| pin_dir | input | 1 | Pin direction, 1 = output |
| pin_o | output | 1 | Pin level |
| pin_oe | output | 1 | Pin output enable |
| count_o | output | 8 | Current count |
| cmp_flag | output | 1 | Compare match flag |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Compare values 0 through 63, plus 128, 200 and 255, are each swept at divide-by-1. The measured toggle interval must equal compare+1 cycles, which separates an off-by-one top value from a correct clear. A fixed compare value is then run under every divider code, and the interval scaling by N exposes a wrong divider encoding. Directed sequences cover the remaining behaviours: a compare value lowered under the count (the match must come only after the wrap), a count load equal to the compare value (the match must be blocked), a clear colliding with a set, and the irq enables examined with the counter stopped so that the flags stay still.

// File: rtl/ctc_timer_pkg.sv
package ctc_timer_pkg;
  localparam int PSC_W = 10;
  localparam logic [1:0] MODE_CTC   = 2'd2;
  localparam logic [1:0] COM_TOGGLE = 2'd1;
  localparam logic [2:0] A_COUNT = 3'd0;
  localparam logic [2:0] A_CMP   = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_IE    = 3'd3;
  localparam logic [2:0] A_CLR   = 3'd4;

  function automatic int div_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    div_shift = 3;
      3'd3:    div_shift = 5;
      3'd4:    div_shift = 6;
      3'd5:    div_shift = 7;
      3'd6:    div_shift = 8;
      3'd7:    div_shift = 10;
      default: div_shift = 0;
    endcase
  endfunction
endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler
  import ctc_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PSC_W-1:0] div_q, div_d, mask;

  always_comb begin
    div_d = div_q + PSC_W'(1);
    mask  = PSC_W'((1 << div_shift(sel)) - 1);
    tick  = (sel != 3'd0) && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ctc_counter.sv
module ctc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctc_en,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             match_ev,
  output logic             wrap_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             blk_q, blk_d;

  always_comb begin
    match_ev = tick && !ld_en && !blk_q && (cnt_q == top);
    wrap_ev  = tick && !ld_en && (cnt_q == CNT_MAX);
    cnt_d    = cnt_q;
    blk_d    = blk_q;
    if (ld_en) begin
      cnt_d = ld_val;
      blk_d = 1'b1;
    end else if (tick) begin
      blk_d = 1'b0;
      cnt_d = (ctc_en && match_ev) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assign cnt = cnt_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en) |=> $stable(cnt_q)); // R2
  AST_CTC_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && ctc_en) |=> (cnt_q == '0)); // R4
  AST_LOAD_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt_q == $past(ld_val))); // R11
endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
  import ctc_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_ev,
  input  logic [1:0] com,
  output logic       wave
);
  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    if (match_ev && (com == COM_TOGGLE)) wave_d = ~wave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && com == COM_TOGGLE) |=> (wave_q != $past(wave_q))); // R7
  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_ev && com == COM_TOGGLE) |=> $stable(wave_q)); // R7
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import ctc_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             pin_dir,
  output logic             pin_o,
  output logic             pin_oe,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_flag,
  output logic             ovf_flag,
  output logic             irq
);
  logic [1:0] rsync_q;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ln = rsync_q[1];

  logic [CNT_W-1:0] top_q, top_d;
  logic [2:0]       sel_q, sel_d;
  logic [1:0]       mode_q, mode_d, com_q, com_d, ie_q, ie_d;
  logic             cmpf_q, cmpf_d, ovff_q, ovff_d;
  logic             we_cnt, we_top, we_ctrl, we_ie, we_clr;
  logic             tick, match_ev, wrap_ev, wave;

  always_comb begin
    we_cnt  = reg_we && (reg_addr == A_COUNT);
    we_top  = reg_we && (reg_addr == A_CMP);
    we_ctrl = reg_we && (reg_addr == A_CTRL);
    we_ie   = reg_we && (reg_addr == A_IE);
    we_clr  = reg_we && (reg_addr == A_CLR);

    top_d  = we_top  ? reg_wdata      : top_q;
    sel_d  = we_ctrl ? reg_wdata[2:0] : sel_q;
    mode_d = we_ctrl ? reg_wdata[4:3] : mode_q;
    com_d  = we_ctrl ? reg_wdata[6:5] : com_q;
    ie_d   = we_ie   ? reg_wdata[1:0] : ie_q;

    cmpf_d = match_ev ? 1'b1 : ((we_clr && reg_wdata[0]) ? 1'b0 : cmpf_q);
    ovff_d = wrap_ev  ? 1'b1 : ((we_clr && reg_wdata[1]) ? 1'b0 : ovff_q);
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      top_q  <= '0;
      sel_q  <= 3'd0;
      mode_q <= 2'd0;
      com_q  <= 2'd0;
      ie_q   <= 2'd0;
      cmpf_q <= 1'b0;
      ovff_q <= 1'b0;
    end else begin
      top_q  <= top_d;
      sel_q  <= sel_d;
      mode_q <= mode_d;
      com_q  <= com_d;
      ie_q   <= ie_d;
      cmpf_q <= cmpf_d;
      ovff_q <= ovff_d;
    end
  end

  ctc_prescaler u_psc (
    .clk   (clk),
    .rst_n (rst_ln),
    .sel   (sel_q),
    .tick  (tick)
  );

  ctc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ln),
    .tick     (tick),
    .ctc_en   (mode_q == MODE_CTC),
    .ld_en    (we_cnt),
    .ld_val   (reg_wdata),
    .top      (top_q),
    .cnt      (count_o),
    .match_ev (match_ev),
    .wrap_ev  (wrap_ev)
  );

  ctc_wave u_wave (
    .clk      (clk),
    .rst_n    (rst_ln),
    .match_ev (match_ev),
    .com      (com_q),
    .wave     (wave)
  );

  assign pin_oe   = pin_dir;
  assign pin_o    = pin_dir & wave;
  assign cmp_flag = cmpf_q;
  assign ovf_flag = ovff_q;
  assign irq      = (cmpf_q & ie_q[0]) | (ovff_q & ie_q[1]);

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_ln)
    wrap_ev |=> ovff_q); // R3
  AST_CMP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ln)
    match_ev |=> cmpf_q); // R9
  AST_STOPPED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_ln)
    (sel_q == 3'd0) |-> !match_ev && !wrap_ev); // R2
endmodule

// File: tb/tb_ctc_timer.sv
module tb_ctc_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       pin_dir;
  logic       pin_o, pin_oe, cmp_flag, ovf_flag, irq;
  logic [7:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  ctc_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pin_dir(pin_dir), .pin_o(pin_o), .pin_oe(pin_oe),
    .count_o(count_o), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic measure(input int exp, input string req);
    logic prev;
    int n;
    prev = pin_o;
    while (pin_o == prev) step();
    prev = pin_o;
    n = 0;
    do begin step(); n++; end while (pin_o == prev);
    chk(req, n, exp);
  endtask

  initial begin
    int div_tab [8] = '{0, 1, 8, 32, 64, 128, 256, 1024};
    int n;
    logic hold_ok;
    logic [7:0] snap;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0; pin_dir = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 flags", {cmp_flag, ovf_flag}, 0);
    chk("R1 irq/pin", {irq, pin_o}, 0);

    // R2 stopped divider holds count
    repeat (5) step();
    chk("R2 stopped", count_o, 0);

    // R3/R5 normal mode at divide-by-1, compare = 0
    wr(3'd2, 8'd1);
    wr(3'd0, 8'hFD);
    step(); chk("R3 count FE", count_o, 8'hFE); chk("R3 no ovf", ovf_flag, 0);
    step(); chk("R3 count FF", count_o, 8'hFF);
    step(); chk("R3 wrap", count_o, 0); chk("R3 ovf set", ovf_flag, 1);
    step(); chk("R3 no clear in normal", count_o, 1); chk("R5 cmp set", cmp_flag, 1);

    // R4/R7 compare sweep at divide-by-1
    pin_dir = 1'b1;
    wr(3'd2, 8'd49);
    for (int c = 0; c < 64; c++) begin
      wr(3'd1, 8'(c));
      measure(c + 1, "R4 R7 period");
    end
    wr(3'd1, 8'd128); measure(129, "R4 R7 period 128");
    wr(3'd1, 8'd200); measure(201, "R4 R7 period 200");
    wr(3'd1, 8'd255); measure(256, "R4 R7 period 255");

    // R2 divider codes with compare = 3
    wr(3'd1, 8'd3);
    for (int p = 1; p < 8; p++) begin
      wr(3'd2, 8'(48 + p));
      measure(4 * div_tab[p], "R2 divider");
    end

    // R7 output mode 0 holds level
    wr(3'd2, 8'd17);
    snap = {7'd0, pin_o};
    hold_ok = 1'b1;
    for (int i = 0; i < 40; i++) begin step(); if (pin_o != snap[0]) hold_ok = 1'b0; end
    chk("R7 hold when mode 0", hold_ok, 1);

    // R8 pin direction
    wr(3'd2, 8'd49);
    wr(3'd1, 8'd2);
    pin_dir = 1'b0;
    hold_ok = 1'b1;
    for (int i = 0; i < 30; i++) begin step(); if (pin_o || pin_oe) hold_ok = 1'b0; end
    chk("R8 undriven", hold_ok, 1);
    pin_dir = 1'b1; #1;
    chk("R8 oe", pin_oe, 1);

    // R6 missed match after lowering compare
    wr(3'd0, 8'd50);
    wr(3'd4, 8'd3);
    wr(3'd1, 8'd20);
    n = 0;
    while (!cmp_flag) begin step(); n++; end
    chk("R6 missed match delay", n, (255 - 52) + 1 + 20 + 1);
    chk("R6 wrapped first", ovf_flag, 1);
    chk("R4 cleared at top", count_o, 0);

    // R11 count load blocks next match
    wr(3'd4, 8'd3);
    wr(3'd0, 8'd20);
    chk("R11 loaded", count_o, 20);
    step();
    chk("R11 blocked count", count_o, 21);
    chk("R11 blocked flag", cmp_flag, 0);
    wr(3'd0, 8'd19);
    step();
    step();
    chk("R4 clear after unblocked", count_o, 0);
    chk("R5 flag after unblocked", cmp_flag, 1);

    // R9 set wins over clear
    wr(3'd1, 8'd5);
    wr(3'd0, 8'd0);
    wr(3'd4, 8'd3);
    chk("R9 cleared", {cmp_flag, ovf_flag}, 0);
    repeat (4) step();
    chk("R9 count before match", count_o, 5);
    wr(3'd4, 8'd1);
    chk("R9 set wins", cmp_flag, 1);
    wr(3'd2, 8'd48);

    // R10 irq enables with counter stopped
    chk("R10 disabled", irq, 0);
    wr(3'd3, 8'd1); chk("R10 cmp enabled", irq, 1);
    wr(3'd3, 8'd2); chk("R10 ovf only", irq, 0);
    wr(3'd3, 8'd3);
    wr(3'd4, 8'd1);
    chk("R9 clear cmp", cmp_flag, 0);
    chk("R10 after clear", irq, 0);
    snap = count_o;
    repeat (10) step();
    chk("R2 stopped holds", count_o, snap);

    finish_run();
  end
endmodule